// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a binary counter whose direction is selected by which of two count inputs pulses. A rising edge on the up-count input adds one, and a rising edge on the down-count input subtracts one. The count wraps around at both ends. An active-high clear sets the count to zero. An active-low load copies a data word into the count. Two active-low terminal-count outputs flag the top and bottom of the range. Each flag is gated by the low phase of its own count input, so a following stage can take that flag as its count input.

The block sits in a system clock domain. The two count inputs and the load input are not tied to that clock. They pass through multi-flop synchronizers, and the count inputs are then edge-detected. A count input edge therefore moves the count on the third system clock edge after the input changes. While the load input is held low, the count follows the data word. The data word must be steady while load is held low.

Top module: `udc_dual_clk_counter`

## Requirements
- R1: While `clr` is high, `q` is 0 at once, without waiting for a clock edge. This overrides load and both count inputs.
- R2: While `clr` is low and `load_n` is held low, `q` takes the value of `din`. Count input edges have no effect during this time.
- R3: A rising edge on `up_clk` while `dn_clk` is high raises `q` by one. The new value appears on the third `clk` rising edge after the input change.
- R4: A rising edge on `dn_clk` while `up_clk` is high lowers `q` by one, with the same latency.
- R5: Counting up from 15 gives 0.
- R6: Counting down from 0 gives 15.
- R7: Each rising edge of a count input gives exactly one step. Holding the input high adds no further steps.
- R8: If rising edges on both count inputs are detected in the same `clk` cycle, `q` does not change.
- R9: `tc_up_n` is 0 exactly when `q` is 15 and the synchronized `up_clk` is low. Otherwise it is 1.
- R10: `tc_dn_n` is 0 exactly when `q` is 0 and the synchronized `dn_clk` is low. Otherwise it is 1.
- R11: With no clear, no load and no qualified edge, `q` holds. A rising edge on `up_clk` while `dn_clk` is low does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous active-high master clear |
| up_clk | input | 1 | Count-up input; rising edge counts |
| dn_clk | input | 1 | Count-down input; rising edge counts |
| load_n | input | 1 | Active-low parallel load |
| din | input | 4 | Load data |
| q | output | 4 | Count value |
| tc_up_n | output | 1 | Active-low terminal count, up direction |
| tc_dn_n | output | 1 | Active-low terminal count, down direction |

## Verification
The bench drives both wrap points:
- A design that saturates, or that drops the carry wrongly, shows 15 or a wrong value where 0 is expected.
- The mirror case shows 0 where 15 is expected.

It raises both count inputs in the same cycle; a design without the tie rule moves the count by one. It raises the up input while the down input is low. It then releases the down input, which must give exactly one down step. A design that ignores the other input's level counts twice or in the wrong direction.

It holds load low while pulsing, and asserts clear mid-run. A wrong priority shows up as a count moving away from `din` or from 0. The terminal-count flags are checked with the count input both high and low at the extreme values. A flag that ignores the input level is caught when it falls while that input is high.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_LOAD = 2'd3
  } step_t;
endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or posedge clr) begin
          if (clr) stg[i] <= RST_VAL;
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge clr) begin
          if (clr) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/udc_edge.sv
module udc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) prev <= '1;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (clr)
    (rise != '0) |=> ((rise & $past(rise)) == '0)); // R7
endmodule

// File: rtl/udc_core.sv
module udc_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld_act,
  input  logic [WIDTH-1:0] din,
  input  logic             up_rise,
  input  logic             dn_rise,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic [WIDTH-1:0] cnt
);
  step_t step;

  always_comb begin
    step = STEP_HOLD;
    if (ld_act)                        step = STEP_LOAD;
    else if (up_rise && dn_rise)       step = STEP_HOLD;
    else if (up_rise && dn_lvl)        step = STEP_INC;
    else if (dn_rise && up_lvl)        step = STEP_DEC;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) cnt <= '0;
    else begin
      case (step)
        STEP_LOAD: cnt <= din;
        STEP_INC:  cnt <= cnt + 1'b1;
        STEP_DEC:  cnt <= cnt - 1'b1;
        default:   cnt <= cnt;
      endcase
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (clr)
    ld_act |=> (cnt == $past(din))); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (clr)
    (!ld_act && up_rise && !dn_rise && dn_lvl) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_DN_STEP: assert property (@(posedge clk) disable iff (clr)
    (!ld_act && dn_rise && !up_rise && up_lvl) |=> (cnt == $past(cnt) - 1'b1)); // R4
  AST_TIE_HOLD: assert property (@(posedge clk) disable iff (clr)
    (!ld_act && up_rise && dn_rise) |=> $stable(cnt)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (clr)
    (!ld_act && !up_rise && !dn_rise) |=> $stable(cnt)); // R11
endmodule

// File: rtl/udc_dual_clk_counter.sv
module udc_dual_clk_counter #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             up_clk,
  input  logic             dn_clk,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc_up_n,
  output logic             tc_dn_n
);
  localparam int NSYNC = 3;
  localparam logic [WIDTH-1:0] TOP_VAL = '1;

  logic [NSYNC-1:0] raw, lvl;
  logic [1:0]       rise;
  logic [WIDTH-1:0] cnt;

  assign raw = {load_n, dn_clk, up_clk};

  udc_sync #(.WIDTH(NSYNC), .STAGES(STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .clr(clr), .d(raw), .q(lvl)
  );

  udc_edge #(.N(2)) u_edge (
    .clk(clk), .clr(clr), .lvl(lvl[1:0]), .rise(rise)
  );

  udc_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .clr(clr), .ld_act(~lvl[2]), .din(din),
    .up_rise(rise[0]), .dn_rise(rise[1]),
    .up_lvl(lvl[0]), .dn_lvl(lvl[1]), .cnt(cnt)
  );

  assign q       = cnt;
  assign tc_up_n = ~((cnt == TOP_VAL) && !lvl[0]);
  assign tc_dn_n = ~((cnt == '0) && !lvl[1]);

  AST_TC_EXCL: assert property (@(posedge clk) disable iff (clr)
    !(!tc_up_n && !tc_dn_n)); // R9
  AST_TC_UP_IDLE: assert property (@(posedge clk) disable iff (clr)
    $past(up_clk) && up_clk && $past(up_clk, 2) |-> tc_up_n); // R9
  AST_TC_DN_IDLE: assert property (@(posedge clk) disable iff (clr)
    $past(dn_clk) && dn_clk && $past(dn_clk, 2) |-> tc_dn_n); // R10
endmodule

// File: tb/udc_dual_clk_counter_bench.sv
module udc_dual_clk_counter_bench;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       up_clk = 1'b1, dn_clk = 1'b1, load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic       tc_up_n, tc_dn_n;

  typedef struct { logic [5:0] exp; string tag; } item_t;
  item_t      sb[$];
  event       sample_ev;
  int         n_chk = 0, n_bad = 0;
  logic [3:0] m = 4'd0;

  always #2 clk = ~clk;

  udc_dual_clk_counter u_udc_dual_clk_counter (
    .clk(clk), .clr(clr), .up_clk(up_clk), .dn_clk(dn_clk),
    .load_n(load_n), .din(din), .q(q), .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n)
  );

  // monitor: pops the next expectation and compares it with the ports
  initial forever begin
    @(sample_ev);
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if ({q, tc_up_n, tc_dn_n} !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got q=%0d tcu=%b tcd=%b, expected q=%0d tcu=%b tcd=%b",
                 it.tag, q, tc_up_n, tc_dn_n, it.exp[5:2], it.exp[1], it.exp[0]);
      end
    end
  end

  task automatic expect_now(input string tag);
    item_t it;
    it.exp = {m, ~((m == 4'd15) && !up_clk), ~((m == 4'd0) && !dn_clk)};
    it.tag = tag;
    sb.push_back(it);
    -> sample_ev;
    #0.5;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_up(input string tag);
    @(negedge clk); up_clk = 1'b0; settle(); expect_now(tag);
    @(negedge clk); up_clk = 1'b1; settle();
    if (load_n && dn_clk) m = m + 4'd1;
    expect_now(tag);
  endtask

  task automatic pulse_dn(input string tag);
    @(negedge clk); dn_clk = 1'b0; settle(); expect_now(tag);
    @(negedge clk); dn_clk = 1'b1; settle();
    if (load_n && up_clk) m = m - 4'd1;
    expect_now(tag);
  endtask

  task automatic do_load(input logic [3:0] v, input string tag);
    @(negedge clk); din = v; load_n = 1'b0; settle();
    m = v; expect_now(tag);
    @(negedge clk); load_n = 1'b1; settle(); expect_now(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    m = 4'd0; expect_now("R1 reset state");
    clr = 1'b0; settle(); expect_now("R11 idle after reset");

    pulse_up("R3 up step");
    pulse_up("R3 up step again");
    pulse_dn("R4 down step");

    // R7: a long high phase gives one step only
    @(negedge clk); up_clk = 1'b0; settle();
    @(negedge clk); up_clk = 1'b1; repeat (20) @(negedge clk);
    m = m + 4'd1; expect_now("R7 single step per edge");

    do_load(4'd13, "R2 load value");
    pulse_up("R3 up to 14");
    pulse_up("R9 up to 15 with tc");
    pulse_up("R5 wrap up to 0");

    pulse_dn("R10 tc down at zero / R6 wrap down");
    if (m != 4'd15) $display("bench model mismatch");
    pulse_dn("R4 down from 15");

    // R8: both inputs rise in the same cycle
    @(negedge clk); up_clk = 1'b0; dn_clk = 1'b0; settle();
    expect_now("R8 both low");
    @(negedge clk); up_clk = 1'b1; dn_clk = 1'b1; settle();
    expect_now("R8 simultaneous edges hold");

    // R11: up edge while down input low is ignored; releasing down counts down once
    @(negedge clk); dn_clk = 1'b0; settle();
    @(negedge clk); up_clk = 1'b0; settle();
    @(negedge clk); up_clk = 1'b1; settle();
    expect_now("R11 up edge with down low ignored");
    @(negedge clk); dn_clk = 1'b1; settle();
    m = m - 4'd1; expect_now("R4 down edge after release");

    // R2: count edges ignored while load held
    @(negedge clk); din = 4'd5; load_n = 1'b0; settle(); m = 4'd5;
    @(negedge clk); up_clk = 1'b0; settle();
    @(negedge clk); up_clk = 1'b1; settle();
    expect_now("R2 load overrides count");
    @(negedge clk); load_n = 1'b1; settle(); expect_now("R2 after load release");

    // R9 and R10: flags stay high when the input is low but the count is not extreme
    @(negedge clk); up_clk = 1'b0; dn_clk = 1'b0; settle();
    expect_now("R9 R10 flags high mid-range");
    @(negedge clk); up_clk = 1'b1; dn_clk = 1'b1; settle();
    expect_now("R8 tie after mid-range");

    // R1: asynchronous clear mid-run, overriding a held load
    do_load(4'd9, "R2 load 9");
    @(negedge clk); load_n = 1'b0; din = 4'd7; #1; clr = 1'b1; #0.5;
    m = 4'd0; expect_now("R1 async clear immediate");
    repeat (6) @(negedge clk); expect_now("R1 clear overrides load");
    load_n = 1'b1; @(negedge clk); clr = 1'b0; settle();
    expect_now("R11 hold after clear");

    for (int k = 0; k < 16; k++) pulse_up("R5 full cycle up");
    for (int k = 0; k < 16; k++) pulse_dn("R6 full cycle down");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule